// File: doc/BRIEF.md
# Four-Lane SD Data CRC16 Generator

This block computes the check words that protect a data block sent over a four-line SD data bus. Payload bytes arrive one per clock on a valid/ready stream. Each byte is cut into two nibbles, high nibble first. Within a nibble, bit L goes to lane L. Each of the four lanes keeps its own 16-bit CRC with generator x^16+x^12+x^5+1 (0x1021).

A flag on the first byte of a block clears all four registers. A flag on the final byte ends the block. The block then stops taking input and emits the four CRCs as an 8-byte stream in bus order. Symbol k (k = 0..15) carries bit 15-k of lanes 3, 2, 1 and 0 as bits 3, 2, 1 and 0. Each two consecutive symbols form one byte, with the earlier symbol in the high half. The bytes are ready to append behind the payload on the same nibble-wide path. Line timing and transmission are handled elsewhere.

Top module: `sd_crc4_gen`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1, and all four lane CRCs are 0.
- R2: A byte accepted with in_start_i=1 is folded into CRCs that start from 0, whatever bytes came before it.
- R3: Each lane folds in one bit at a time. It shifts the CRC left by one, XORs in 0x1021 if the bit shifted out was 1, then XORs in 0x1021 again if the data bit is 1. A single 0xFF byte as a whole block therefore gives 0x3063 in every lane.
- R4: Byte bits 7, 6, 5, 4 feed lanes 3, 2, 1, 0 in the first step. Bits 3, 2, 1, 0 then feed lanes 3, 2, 1, 0 in the second step.
- R5: The result is 8 bytes. Byte j has symbol 2j in bits 7:4 and symbol 2j+1 in bits 3:0. Symbol k holds bit 15-k of lane 3, lane 2, lane 1 and lane 0 in its bits 3, 2, 1 and 0.
- R6: out_valid_o rises in the cycle after a byte with in_last_i=1 is accepted. It stays 0 while non-final bytes are accepted.
- R7: While no result is pending, in_ready_o stays 1, so one byte is accepted in every cycle that in_valid_i is 1.
- R8: While the result is being emitted, in_ready_o is 0. A result byte offered with out_ready_i=0 is held unchanged until it is taken.
- R9: out_last_o is 1 with the eighth result byte and with no other. In the cycle after that byte is taken, in_ready_o is 1 and out_valid_o is 0.
- R10: A byte accepted with in_start_i=0 after a completed block continues from that block's CRC values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block can accept an input byte |
| in_data_i | input | 8 | Payload byte |
| in_start_i | input | 1 | First byte of a block; clears the CRCs |
| in_last_i | input | 1 | Final byte of a block |
| out_valid_o | output | 1 | CRC byte valid |
| out_ready_i | input | 1 | Consumer takes the CRC byte |
| out_data_o | output | 8 | Interleaved CRC byte |
| out_last_o | output | 1 | Eighth CRC byte |

## Verification
A wrong lane register state has no effect at the ports until the block's final byte. It then shows up within the next eight result bytes, as wrong bits in the symbols of the affected lane. Directed single-byte blocks isolate one lane and one bit position. A swap of lanes, of nibble order or of symbol order therefore changes known, hand-computed bytes. Control faults show up sooner, in the cycle right after the final byte is accepted or right after the eighth result byte is taken, through in_ready_o, out_valid_o and out_last_o.

// File: rtl/sd_crc4_pkg.sv
package sd_crc4_pkg;
  localparam int unsigned SD_BYTE_W = 8;

  typedef enum logic {
    ST_ACC  = 1'b0,
    ST_EMIT = 1'b1
  } sd_crc4_state_e;
endpackage

// File: rtl/sd_crc4_split.sv
// Maps a byte onto per-lane bit pairs; bit STEPS-1 of each lane is folded first.
module sd_crc4_split #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned STEPS = BYTE_W / LANES
) (
  input  logic [BYTE_W-1:0]            data_i,
  output logic [LANES-1:0][STEPS-1:0]  lane_bits_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar s = 0; s < STEPS; s++) begin : g_step
      assign lane_bits_o[l][s] = data_i[LANES*s + l];
    end
  end
endmodule

// File: rtl/sd_crc4_lane.sv
module sd_crc4_lane #(
  parameter int unsigned         CRC_W = 16,
  parameter logic [CRC_W-1:0]    POLY  = 16'h1021,
  parameter int unsigned         STEPS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clear_i,
  input  logic [STEPS-1:0]  bits_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  // Unrolled fold of STEPS bits in one cycle, MSB of bits_i first.
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = clear_i ? '0 : crc_q;
    for (int s = STEPS - 1; s >= 0; s--) begin
      fb = c[CRC_W-1];
      c  = c << 1;
      if (fb)        c = c ^ POLY;
      if (bits_i[s]) c = c ^ POLY;
    end
    crc_d = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sd_crc4_pack.sv
// Interleaves lane CRCs into bus symbols and selects one output byte.
module sd_crc4_pack #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned SPB       = BYTE_W / LANES,
  localparam int unsigned OUT_BYTES = LANES * CRC_W / BYTE_W,
  localparam int unsigned IDX_W     = (OUT_BYTES > 1) ? $clog2(OUT_BYTES) : 1
) (
  input  logic [LANES-1:0][CRC_W-1:0]  crc_i,
  input  logic [IDX_W-1:0]             idx_i,
  output logic [BYTE_W-1:0]            byte_o
);
  logic [OUT_BYTES-1:0][BYTE_W-1:0] bytes;

  for (genvar j = 0; j < OUT_BYTES; j++) begin : g_byte
    for (genvar t = 0; t < SPB; t++) begin : g_sym
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bytes[j][(SPB-1-t)*LANES + l] = crc_i[l][CRC_W-1-(j*SPB+t)];
      end
    end
  end

  assign byte_o = bytes[idx_i];
endmodule

// File: rtl/sd_crc4_gen.sv
module sd_crc4_gen
  import sd_crc4_pkg::*;
#(
  parameter int unsigned      LANES = 4,
  parameter int unsigned      CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [SD_BYTE_W-1:0]  in_data_i,
  input  logic                  in_start_i,
  input  logic                  in_last_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [SD_BYTE_W-1:0]  out_data_o,
  output logic                  out_last_o
);
  localparam int unsigned STEPS     = SD_BYTE_W / LANES;
  localparam int unsigned OUT_BYTES = LANES * CRC_W / SD_BYTE_W;
  localparam int unsigned IDX_W     = (OUT_BYTES > 1) ? $clog2(OUT_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(OUT_BYTES - 1);

  sd_crc4_state_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic accept, emit_done;
  logic [LANES-1:0][STEPS-1:0] lane_bits;
  logic [LANES-1:0][CRC_W-1:0] lane_crc;

  assign in_ready_o  = (state_q == ST_ACC);
  assign out_valid_o = (state_q == ST_EMIT);
  assign out_last_o  = out_valid_o && (idx_q == IDX_LAST);
  assign accept      = in_valid_i && in_ready_o;
  assign emit_done   = out_last_o && out_ready_i;

  sd_crc4_split #(.LANES(LANES), .BYTE_W(SD_BYTE_W)) u_split (
    .data_i      (in_data_i),
    .lane_bits_o (lane_bits)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sd_crc4_lane #(.CRC_W(CRC_W), .POLY(POLY), .STEPS(STEPS)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (accept),
      .clear_i (in_start_i),
      .bits_i  (lane_bits[l]),
      .crc_o   (lane_crc[l])
    );
  end

  sd_crc4_pack #(.LANES(LANES), .CRC_W(CRC_W), .BYTE_W(SD_BYTE_W)) u_pack (
    .crc_i  (lane_crc),
    .idx_i  (idx_q),
    .byte_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACC;
    end else if (accept && in_last_i) begin
      state_q <= ST_EMIT;
    end else if (emit_done) begin
      state_q <= ST_ACC;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (out_valid_o && out_ready_i) begin
      idx_q <= emit_done ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/sd_crc4_chk.sv
module sd_crc4_chk #(
  parameter int unsigned OUT_BYTES = 8,
  parameter int unsigned BYTE_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_last_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [BYTE_W-1:0] out_data_o,
  input logic              out_last_o
);
  localparam int unsigned CW = $clog2(OUT_BYTES) + 1;
  logic [CW-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else if (out_valid_o && out_ready_i) beat_q <= out_last_o ? '0 : beat_q + 1'b1;
  end

  AST_ACC_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o); // R7
  AST_EXCL_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R8
  AST_LAST_TO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_last_i |=> out_valid_o); // R6
  AST_NO_EARLY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !in_last_i |=> !out_valid_o); // R6
  AST_LAST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |-> (out_last_o == (beat_q == CW'(OUT_BYTES - 1)))); // R9
  AST_RETURN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> in_ready_o && !out_valid_o); // R9
endmodule

bind sd_crc4_gen sd_crc4_chk #(.OUT_BYTES(OUT_BYTES), .BYTE_W(sd_crc4_pkg::SD_BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_last_i   (in_last_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o)
);

// File: tb/tb_sd_crc4_gen.sv
`timescale 1ns/1ps
module tb_sd_crc4_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_start = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_ready = 1'b0, out_last;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m_crc [4];
  logic [7:0] got [8];

  always #2 clk = ~clk;

  sd_crc4_gen dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_start_i(in_start), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_last_o(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fold_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15];
    c = c << 1;
    if (fb) c = c ^ 16'h1021;
    if (b)  c = c ^ 16'h1021;
    return c;
  endfunction

  function automatic logic [7:0] exp_byte(input int j);
    logic [7:0] r;
    for (int t = 0; t < 2; t++)
      for (int l = 0; l < 4; l++)
        r[(1-t)*4 + l] = m_crc[l][15-(2*j+t)];
    return r;
  endfunction

  task automatic model_byte(input logic [7:0] b, input logic st);
    if (st) for (int l = 0; l < 4; l++) m_crc[l] = '0;
    for (int l = 0; l < 4; l++) begin
      m_crc[l] = fold_bit(m_crc[l], b[4+l]);
      m_crc[l] = fold_bit(m_crc[l], b[l]);
    end
  endtask

  task automatic feed(input logic [7:0] b, input logic st, input logic lst);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_start = st; in_last = lst;
    chk(in_ready == 1'b1, "R7", in_ready, 1);
    chk(out_valid == 1'b0, "R6", out_valid, 0);
    model_byte(b, st);
    @(posedge clk);
    #0.5;
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain(input bit bp);
    int n = 0;
    bit stalled = 0;
    logic [7:0] held = '0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R6", out_valid, 1);
    while (n < 8) begin
      out_ready = bp ? 1'($urandom % 2) : 1'b1;
      #0.1;
      chk(in_ready == 1'b0, "R8", in_ready, 0);
      if (stalled) chk(out_data == held, "R8", out_data, held);
      if (out_valid && out_ready) begin
        got[n] = out_data;
        chk(out_data == exp_byte(n), "R5", out_data, exp_byte(n));
        chk(out_last == (n == 7), "R9", out_last, (n == 7));
        n++;
        stalled = 0;
      end else begin
        stalled = 1;
        held = out_data;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic frame(input int len, input logic st, input bit bp);
    for (int i = 0; i < len; i++)
      feed(8'($urandom), st && (i == 0), i == len - 1);
    drain(bp);
  endtask

  initial begin
    logic [7:0] ref_ff [8];
    logic [7:0] ref_80 [8];
    ref_ff = '{8'h00, 8'hFF, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'h00, 8'hFF};
    ref_80 = '{8'h00, 8'h80, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 8'h80};
    void'($urandom(32'h5D0C_C16A));
    for (int l = 0; l < 4; l++) m_crc[l] = '0;
    #9 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {out_valid, in_ready}, 2'b01);

    // R1: first block without start relies on reset clearing
    feed(8'h00, 1'b0, 1'b1);
    drain(1'b0);
    for (int j = 0; j < 8; j++) chk(got[j] == 8'h00, "R1", got[j], 0);

    // R3: 0xFF single byte gives 0x3063 per lane
    feed(8'hFF, 1'b1, 1'b1);
    drain(1'b0);
    for (int j = 0; j < 8; j++) chk(got[j] == ref_ff[j], "R3", got[j], ref_ff[j]);

    // R4: 0x80 touches only lane 3, first step
    feed(8'h80, 1'b1, 1'b1);
    drain(1'b1);
    for (int j = 0; j < 8; j++) chk(got[j] == ref_80[j], "R4", got[j], ref_80[j]);

    // R2: abandoned partial block, then a fresh start
    for (int i = 0; i < 5; i++) feed(8'($urandom), 1'b0, 1'b0);
    feed(8'h80, 1'b1, 1'b1);
    drain(1'b0);
    for (int j = 0; j < 8; j++) chk(got[j] == ref_80[j], "R2", got[j], ref_80[j]);

    // R10: continue without start after a completed block
    frame(7, 1'b0, 1'b1);

    // long zero block stays zero
    for (int i = 0; i < 16; i++) feed(8'h00, i == 0, i == 15);
    drain(1'b0);
    for (int j = 0; j < 8; j++) chk(got[j] == 8'h00, "R3", got[j], 0);

    for (int f = 0; f < 40; f++)
      frame(1 + int'($urandom % 64), 1'b1, 1'($urandom % 2));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule